// File: doc/BRIEF.md
# Port Pin Alternate-Function Override Slice

This block drives the pad controls for four neighbouring pins of a microcontroller I/O port. Each pin has a direction bit and an output-data bit in local registers. Several peripherals can take over a pin: a serial peripheral interface running as master, a shift-register serial interface working in two-wire open-drain mode on this port, a toggle strobe from that interface, the pin-change interrupt masks and the analog digital-disable bits. For every pin the block builds enable/value override pairs for pull-up, direction, output value, toggle and digital input enable. It resolves them against the register bits to get the pad output enable, the pad output value and the pad pull-up request.

Pad inputs pass through a synchronizer before they reach the pin-read bus. The read value is forced to zero while the pin's digital input is disabled. Vector bit index i carries pin 4+i: index 0 is the serial data pin, index 1 the serial clock pin, index 2 the slave-select pin and index 3 the analog-only pin. Below, "SPI master" means spi_en AND spi_master, and "two-wire here" means ser_twowire AND ser_pos.

Top module: `port_af_slice`

## Requirements
- R1: After a synchronous active-low reset, dir_q, out_q and pin_sync are all 0.
- R2: A pin with no active override has pad_oe = dir_q, pad_out = out_q, and pad_pullup = (NOT pad_oe) AND out_q AND NOT pu_global_off. Pull-up and output enable are never both 1. The pin's digital input is enabled. dir_q takes dir_wdata on the edge after dir_we.
- R3: Index 3 has no pull-up, direction, value or toggle override. Its digital input is enabled when pchg_en AND pchg_mask[3] is 1, or when adc_dig_off[3] is 0.
- R4: In SPI master, index 2 and index 0 take a pull-up override of out_q AND NOT pu_global_off. Index 2 also has its direction forced to input. Index 2's digital input follows the same rule as index 3, using its own bits.
- R5: Under SPI master or two-wire here, index 1 direction = (ser_clk_hold OR out_q[1]) AND dir_q[1].
- R6: Index 1 pad_out is spi_sck_out under SPI master. Otherwise it is 0 when two-wire here and dir_q[1] are both set. Otherwise it is out_q[1].
- R7: Index 0 direction is 0 under SPI master. Otherwise, under two-wire here, it is (ser_shift_out OR out_q[0]) AND dir_q[0]. Index 0 pad_out is spi_mosi_out under SPI master. Otherwise it is 0 under two-wire here with dir_q[0] set.
- R8: For indices 1 and 0, the digital input is enabled when (ser_start_ie AND ser_pos) is 1, when pchg_en AND pchg_mask[i] is 1, or when adc_dig_off[i] is 0.
- R9: With ser_tog_en AND ser_pos and ser_tog_stb, out_q[1] inverts on the next edge. A simultaneous out_we wins and loads out_wdata.
- R10: pin_sync[i] equals pad_in[i] delayed by two clock edges, ANDed with the pin's current digital input enable.
- R11: SPI master takes precedence over two-wire mode on indices 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_we | input | 1 | Direction register write strobe |
| dir_wdata | input | 4 | Direction write data |
| out_we | input | 1 | Output register write strobe |
| out_wdata | input | 4 | Output write data |
| pu_global_off | input | 1 | Disables all pull-ups |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI master mode |
| spi_sck_out | input | 1 | SPI clock from the SPI engine |
| spi_mosi_out | input | 1 | SPI data out from the SPI engine |
| ser_twowire | input | 1 | Shift interface in two-wire mode |
| ser_pos | input | 1 | Shift interface mapped onto this port |
| ser_clk_hold | input | 1 | Shift interface clock-hold request |
| ser_shift_out | input | 1 | Shift interface data-out bit |
| ser_tog_en | input | 1 | Shift interface toggle enable |
| ser_tog_stb | input | 1 | Toggle strobe |
| ser_start_ie | input | 1 | Start-condition interrupt enable |
| pchg_en | input | 1 | Pin-change interrupt group enable |
| pchg_mask | input | 4 | Pin-change masks |
| adc_dig_off | input | 4 | Analog digital-input disable bits |
| pad_in | input | 4 | Raw pad inputs |
| pad_oe | output | 4 | Resolved pad output enable |
| pad_out | output | 4 | Resolved pad output value |
| pad_pullup | output | 4 | Resolved pull-up request |
| pin_sync | output | 4 | Synchronized, gated pin read |
| dir_q | output | 4 | Direction register |
| out_q | output | 4 | Output register |

## Verification
A toggle strobe and a register write to the output register can land on the same edge. The bench drives ser_tog_stb and out_we together, with different data, and expects the written value (R9). It also checks a strobe without a write, where bit 1 inverts. The SPI master and two-wire selections are likewise asserted together. In that case index 1 must show the SPI clock and index 0 must be an input, which shows that SPI master has priority (R11).

// File: rtl/port_af_pkg.sv
// Shared types for the port override slice.
// Assumes index i of every vector is pin 4+i of the port.
package port_af_pkg;
    localparam int PINS = 4;

    typedef enum logic [1:0] {
        PK_DATA   = 2'd0,
        PK_SCLK   = 2'd1,
        PK_SELECT = 2'd2,
        PK_ANALOG = 2'd3
    } pin_kind_t;

    typedef struct packed {
        logic pu_oe;
        logic pu_ov;
        logic dd_oe;
        logic dd_ov;
        logic pv_oe;
        logic pv_ov;
        logic pt_oe;
        logic di_oe;
        logic di_ov;
    } ovr_t;

    function automatic pin_kind_t kind_of(input int idx);
        case (idx)
            0:       return PK_DATA;
            1:       return PK_SCLK;
            2:       return PK_SELECT;
            default: return PK_ANALOG;
        endcase
    endfunction
endpackage

// File: rtl/af_override_gen.sv
// Builds the override enable/value pairs of one pin; KIND picks the pin's role.
// Assumes all inputs are qualified levels from the owning peripherals.
module af_override_gen
    import port_af_pkg::*;
#(
    parameter pin_kind_t KIND = PK_ANALOG
) (
    input  logic spi_m,
    input  logic tw_here,
    input  logic pos,
    input  logic clk_hold,
    input  logic shift_out,
    input  logic tog_en,
    input  logic start_ie,
    input  logic pc_hit,
    input  logic adc_off,
    input  logic dir_bit,
    input  logic out_bit,
    input  logic pud,
    input  logic sck,
    input  logic mosi,
    output ovr_t ovr
);
    // Per-kind override equations.
    always_comb begin
        ovr = '0;
        case (KIND)
            PK_ANALOG: begin
                ovr.di_oe = adc_off | pc_hit;
                ovr.di_ov = pc_hit;
            end
            PK_SELECT: begin
                ovr.pu_oe = spi_m;
                ovr.pu_ov = out_bit & ~pud;
                ovr.dd_oe = spi_m;
                ovr.dd_ov = 1'b0;
                ovr.di_oe = adc_off | pc_hit;
                ovr.di_ov = pc_hit;
            end
            PK_SCLK: begin
                ovr.dd_oe = spi_m | tw_here;
                ovr.dd_ov = (clk_hold | out_bit) & dir_bit;
                ovr.pv_oe = spi_m | (tw_here & dir_bit);
                ovr.pv_ov = spi_m ? sck : 1'b0;
                ovr.pt_oe = tog_en & pos;
                ovr.di_oe = adc_off | (start_ie & pos) | pc_hit;
                ovr.di_ov = (start_ie & pos) | pc_hit;
            end
            default: begin
                ovr.pu_oe = spi_m;
                ovr.pu_ov = out_bit & ~pud;
                ovr.dd_oe = spi_m | tw_here;
                ovr.dd_ov = spi_m ? 1'b0 : ((shift_out | out_bit) & dir_bit);
                ovr.pv_oe = spi_m | (tw_here & dir_bit);
                ovr.pv_ov = spi_m ? mosi : 1'b0;
                ovr.di_oe = adc_off | (start_ie & pos) | pc_hit;
                ovr.di_ov = (start_ie & pos) | pc_hit;
            end
        endcase
    end
endmodule

// File: rtl/port_regs.sv
// Direction and output registers; a write to the output register beats a toggle.
// Assumes tog_mask is already qualified by the strobe.
module port_regs #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_we,
    input  logic [W-1:0] dir_wdata,
    input  logic         out_we,
    input  logic [W-1:0] out_wdata,
    input  logic [W-1:0] tog_mask,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q
);
    // Register update with write-over-toggle priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            if (dir_we) dir_q <= dir_wdata;
            if (out_we) out_q <= out_wdata;
            else        out_q <= out_q ^ tog_mask;
        end
    end
endmodule

// File: rtl/input_sync.sv
// Multi-stage pad input synchronizer with a gate on its output.
// Assumes STAGES >= 1.
module input_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic [W-1:0] gate,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the raw pads.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        // Further stages shift the sample along.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1] & gate;
endmodule

// File: rtl/port_af_slice.sv
// Four-pin port slice: override generation, pad resolution, input sync.
// Assumes peripheral controls are synchronous to clk.
module port_af_slice
    import port_af_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dir_we,
    input  logic [PINS-1:0] dir_wdata,
    input  logic            out_we,
    input  logic [PINS-1:0] out_wdata,
    input  logic            pu_global_off,
    input  logic            spi_en,
    input  logic            spi_master,
    input  logic            spi_sck_out,
    input  logic            spi_mosi_out,
    input  logic            ser_twowire,
    input  logic            ser_pos,
    input  logic            ser_clk_hold,
    input  logic            ser_shift_out,
    input  logic            ser_tog_en,
    input  logic            ser_tog_stb,
    input  logic            ser_start_ie,
    input  logic            pchg_en,
    input  logic [PINS-1:0] pchg_mask,
    input  logic [PINS-1:0] adc_dig_off,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_pullup,
    output logic [PINS-1:0] pin_sync,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] out_q
);
    localparam int W = PINS;

    logic         spi_m;
    logic         tw_here;
    logic [W-1:0] pc_hit;
    logic [W-1:0] tog_mask;
    logic [W-1:0] die;
    ovr_t         ovr [W];

    assign spi_m   = spi_en & spi_master;
    assign tw_here = ser_twowire & ser_pos;
    assign pc_hit  = {W{pchg_en}} & pchg_mask;

    port_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_we    (dir_we),
        .dir_wdata (dir_wdata),
        .out_we    (out_we),
        .out_wdata (out_wdata),
        .tog_mask  (tog_mask),
        .dir_q     (dir_q),
        .out_q     (out_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        af_override_gen #(.KIND(kind_of(i))) u_ovr (
            .spi_m     (spi_m),
            .tw_here   (tw_here),
            .pos       (ser_pos),
            .clk_hold  (ser_clk_hold),
            .shift_out (ser_shift_out),
            .tog_en    (ser_tog_en),
            .start_ie  (ser_start_ie),
            .pc_hit    (pc_hit[i]),
            .adc_off   (adc_dig_off[i]),
            .dir_bit   (dir_q[i]),
            .out_bit   (out_q[i]),
            .pud       (pu_global_off),
            .sck       (spi_sck_out),
            .mosi      (spi_mosi_out),
            .ovr       (ovr[i])
        );

        logic pu_sel;

        // Resolve overrides against the register bits for this pin.
        always_comb begin
            pad_oe[i]     = ovr[i].dd_oe ? ovr[i].dd_ov : dir_q[i];
            pad_out[i]    = ovr[i].pv_oe ? ovr[i].pv_ov : out_q[i];
            pu_sel        = ovr[i].pu_oe ? ovr[i].pu_ov : out_q[i];
            pad_pullup[i] = ~pad_oe[i] & pu_sel & ~pu_global_off;
            die[i]        = ovr[i].di_oe ? ovr[i].di_ov : 1'b1;
            tog_mask[i]   = ovr[i].pt_oe & ser_tog_stb;
        end
    end

    input_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .gate  (die),
        .q     (pin_sync)
    );
endmodule

// File: rtl/port_af_checker.sv
// Property checker for port_af_slice, attached by bind.
// Assumes it sees the top module's ports by name.
module port_af_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       dir_we,
    input logic [3:0] dir_wdata,
    input logic       out_we,
    input logic       pu_global_off,
    input logic       spi_en,
    input logic       spi_master,
    input logic       spi_sck_out,
    input logic       ser_pos,
    input logic       ser_tog_en,
    input logic       ser_tog_stb,
    input logic       pchg_en,
    input logic [3:0] pchg_mask,
    input logic [3:0] adc_dig_off,
    input logic [3:0] pad_oe,
    input logic [3:0] pad_out,
    input logic [3:0] pad_pullup,
    input logic [3:0] pin_sync,
    input logic [3:0] dir_q,
    input logic [3:0] out_q
);
    AST_PU_NOT_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pullup & pad_oe) == 4'b0); // R2
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> dir_q == $past(dir_wdata)); // R2
    AST_ANALOG_PIN_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[3] == dir_q[3]) && (pad_out[3] == out_q[3])); // R3
    AST_SELECT_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && spi_master) |-> !pad_oe[2] && !pad_oe[0]); // R4
    AST_SPI_CLK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && spi_master) |-> pad_out[1] == spi_sck_out); // R11
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_we && ser_tog_en && ser_pos && ser_tog_stb) |=> out_q[1] != $past(out_q[1])); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_we && !ser_tog_stb) |=> $stable(out_q)); // R9
    AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_dig_off[3] && !(pchg_en && pchg_mask[3])) |-> !pin_sync[3]); // R10
    AST_PULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pu_global_off |-> pad_pullup == 4'b0); // R2
endmodule

bind port_af_slice port_af_checker u_chk (.*);

// File: tb/tb_port_af_slice.sv
module tb_port_af_slice;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_we = 0, out_we = 0, pu_global_off = 0;
    logic [3:0] dir_wdata = 0, out_wdata = 0;
    logic spi_en = 0, spi_master = 0, spi_sck_out = 0, spi_mosi_out = 0;
    logic ser_twowire = 0, ser_pos = 0, ser_clk_hold = 0, ser_shift_out = 0;
    logic ser_tog_en = 0, ser_tog_stb = 0, ser_start_ie = 0, pchg_en = 0;
    logic [3:0] pchg_mask = 0, adc_dig_off = 0, pad_in = 0;
    logic [3:0] pad_oe, pad_out, pad_pullup, pin_sync, dir_q, out_q;

    int tests = 0, fails = 0;
    bit done = 0;
    bit live = 0;

    // behavioural model state
    logic [3:0] m_dir = 0, m_out = 0, m_s1 = 0, m_s2 = 0;

    always #10 clk = ~clk;

    port_af_slice dut (.*);

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 0; m_out = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            m_s2 = m_s1;
            m_s1 = pad_in;
            if (dir_we) m_dir = dir_wdata;
            if (out_we) m_out = out_wdata;
            else if (ser_tog_en && ser_pos && ser_tog_stb) m_out[1] = ~m_out[1];
        end
    end

    task automatic compare_all();
        logic [3:0] e_oe, e_out, e_pu, e_die;
        bit sm, tw, sie;
        sm = spi_en && spi_master;
        tw = ser_twowire && ser_pos;
        sie = ser_start_ie && ser_pos;
        e_oe = m_dir; e_out = m_out; e_pu = m_out;
        for (int i = 0; i < 4; i++) begin
            bit pc;
            pc = pchg_en && pchg_mask[i];
            e_die[i] = pc || !adc_dig_off[i] || (i < 2 && sie);
        end
        if (sm) begin
            e_oe[2] = 0; e_pu[2] = m_out[2] && !pu_global_off;
            e_oe[0] = 0; e_pu[0] = m_out[0] && !pu_global_off;
            e_oe[1] = (ser_clk_hold || m_out[1]) && m_dir[1];
            e_out[1] = spi_sck_out; e_out[0] = spi_mosi_out;
        end else if (tw) begin
            e_oe[1] = (ser_clk_hold || m_out[1]) && m_dir[1];
            e_oe[0] = (ser_shift_out || m_out[0]) && m_dir[0];
            if (m_dir[1]) e_out[1] = 0;
            if (m_dir[0]) e_out[0] = 0;
        end
        e_pu = e_pu & ~e_oe & {4{!pu_global_off}};
        chk("R2 R4 R5 R7 R11 pad_oe", pad_oe, e_oe);
        chk("R2 R6 R7 R11 pad_out", pad_out, e_out);
        chk("R2 R4 pad_pullup", pad_pullup, e_pu);
        chk("R3 R8 R10 pin_sync", pin_sync, m_s2 & e_die);
        chk("R2 R9 regs", {dir_q, out_q} [7:4], m_dir);
        chk("R9 out_q", out_q, m_out);
    endtask

    always @(negedge clk) begin
        if (live) begin
            #1 compare_all();
        end
    end

    task automatic idle();
        dir_we = 0; out_we = 0; ser_tog_stb = 0;
        spi_en = 0; spi_master = 0; ser_twowire = 0; ser_pos = 0;
        ser_tog_en = 0; ser_start_ie = 0; pchg_en = 0; pchg_mask = 0;
        adc_dig_off = 0; pu_global_off = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #2;
        chk("R1 dir_q", dir_q, 4'h0);
        chk("R1 out_q", out_q, 4'h0);
        chk("R1 pin_sync", pin_sync, 4'h0);
        live = 1;

        // R9 toggle alone, then toggle with write
        @(negedge clk);
        ser_tog_en = 1; ser_pos = 1; ser_tog_stb = 1;
        @(negedge clk); ser_tog_stb = 0; #2;
        chk("R9 toggle flips bit1", out_q, 4'b0010);
        @(negedge clk);
        ser_tog_stb = 1; out_we = 1; out_wdata = 4'b0110;
        @(negedge clk); ser_tog_stb = 0; out_we = 0; #2;
        chk("R9 write beats toggle", out_q, 4'b0110);

        // R11 SPI master and two-wire together
        @(negedge clk);
        dir_we = 1; dir_wdata = 4'b0011;
        @(negedge clk);
        dir_we = 0; spi_en = 1; spi_master = 1; ser_twowire = 1; spi_sck_out = 1;
        spi_mosi_out = 1; #2;
        chk("R11 sclk pin shows spi clock", {3'b0, pad_out[1]}, 4'b0001);
        chk("R11 data pin is input", {3'b0, pad_oe[0]}, 4'b0000);

        // R10 gating and R3 override value
        @(negedge clk);
        idle(); pad_in = 4'hF; adc_dig_off = 4'hF;
        repeat (3) @(negedge clk); #2;
        chk("R10 read gated to zero", pin_sync, 4'h0);
        adc_dig_off = 4'h0; #1;
        chk("R10 read released", pin_sync, 4'hF);
        adc_dig_off = 4'hF; pchg_en = 1; pchg_mask = 4'b1000; #1;
        chk("R3 pin-change keeps input on", pin_sync, 4'b1000);
        ser_pos = 1; ser_start_ie = 1; #1;
        chk("R8 start interrupt keeps input on", pin_sync, 4'b1011);

        // randomized sweep
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            dir_we = ($urandom_range(0, 7) == 0); dir_wdata = 4'($urandom);
            out_we = ($urandom_range(0, 7) == 0); out_wdata = 4'($urandom);
            pu_global_off = ($urandom_range(0, 5) == 0);
            spi_en = 1'($urandom); spi_master = 1'($urandom);
            spi_sck_out = 1'($urandom); spi_mosi_out = 1'($urandom);
            ser_twowire = 1'($urandom); ser_pos = 1'($urandom);
            ser_clk_hold = 1'($urandom); ser_shift_out = 1'($urandom);
            ser_tog_en = 1'($urandom); ser_tog_stb = 1'($urandom);
            ser_start_ie = 1'($urandom); pchg_en = 1'($urandom);
            pchg_mask = 4'($urandom); adc_dig_off = 4'($urandom);
            pad_in = 4'($urandom);
        end
        @(negedge clk);
        idle();
        @(negedge clk); #3;
        live = 0;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule